// File: doc/BRIEF.md
# Double-talk adaptation controller

This block sits beside an adaptive echo-cancelling filter and decides, once per sample, how fast that filter may adapt. It follows the short-term magnitude of the far-end reference signal and of the near-end input. It compares the near-end level with the far-end level scaled by a programmable fraction. From that comparison it chooses one of three speeds: full-speed adaptation, adaptation slowed by a power of two, or no adaptation. Cancellation itself carries on in every case. Only coefficient updates are affected.

The comparison works on linear magnitudes. The far-end level is multiplied by a Q15 fraction, so no logarithm hardware is needed. The near-end level is then tested against that product and against half of it. A level above the product counts as clear double-talk. A level between the half and the full product is treated as doubtful. After clear double-talk, a hangover keeps adaptation stopped for a fixed number of further samples. Samples arrive with a one-cycle strobe. The decision for a sample appears two clock edges after the edge that takes that sample.

Top module: `dtalk_adapt_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `adapt_mode` is 0 (normal), `adapt_halt` is 0 and `step_shift` is 0. `adapt_mode` never takes the value 3.
- R2: At each strobe, each tracked level becomes the larger of two values: the magnitude of the new sample, and the old level minus the old level shifted right by 5. The magnitude of -32768 is 32768.
- R3: The threshold register resets to 0x4800 (0.5625). A cycle with `thr_wr` high loads `thr_wdata`, and the new value is used for every later sample.
- R4: Let scaled = (far level × threshold) >> 15. When the near level is strictly greater than scaled, the decision is halt: `adapt_mode` = 2, `adapt_halt` = 1, `step_shift` = 0.
- R5: When the near level is not above scaled but is strictly above scaled >> 1, and `slow_sel` is not zero, the decision is slow: `adapt_mode` = 1, `adapt_halt` = 0, `step_shift` = `slow_sel`.
- R6: In the doubtful band of R5 with `slow_sel` equal to zero, the decision is halt (mode 2, halt 1, step 0).
- R7: After a sample judged as double-talk, the next 256 samples are forced to halt whatever their levels. Another double-talk sample restarts the count.
- R8: Any sample that R4 to R7 do not cover gives normal: mode 0, halt 0, step 0.
- R9: The outputs for a sample change only on the second clock edge after the edge on which `smp_valid` was high. At all other edges they hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample pair |
| rin_smp | input | 16 | Far-end reference sample, two's complement |
| sin_smp | input | 16 | Near-end input sample, two's complement |
| thr_wr | input | 1 | Load enable for the threshold register |
| thr_wdata | input | 16 | New threshold, Q15 fraction below 1 |
| slow_sel | input | 3 | Right-shift applied to the step in the doubtful band |
| adapt_mode | output | 2 | 0 normal, 1 slow, 2 halt |
| adapt_halt | output | 1 | High when adaptation must stop |
| step_shift | output | 3 | Step-size right shift for the filter |

## Verification
The hangover and the doubtful-band test can apply to the same sample. Once a burst of clear double-talk ends, the near-end level decays through the doubtful band while the hangover is still counting, so the block must report halt even though the band alone would give slow. The bench provokes this with a loud near-end burst followed by a strong far-end signal and silence at the near end. A level model in the bench then decides, sample by sample, which rule should take precedence. A threshold write and a new strobe can also fall in adjacent cycles. The bench loads the threshold directly before a sample and expects that sample to use the new value.

// File: rtl/dtac_pkg.sv
package dtac_pkg;
  typedef enum logic [1:0] {
    ADP_NORMAL = 2'd0,
    ADP_SLOW   = 2'd1,
    ADP_HALT   = 2'd2
  } adp_mode_e;
endpackage

// File: rtl/dtac_level.sv
// Peak-hold magnitude follower: instant attack, geometric release.
module dtac_level #(
  parameter int DATA_W   = 16,
  parameter int DECAY_SH = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp,
  output logic [DATA_W-1:0] lvl
);
  logic [DATA_W-1:0] mag;
  logic [DATA_W-1:0] decayed;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    mag     = smp[DATA_W-1] ? (~smp + DATA_W'(1)) : smp;
    decayed = lvl - (lvl >> DECAY_SH);
    nxt     = (mag > decayed) ? mag : decayed;
  end

  always_ff @(posedge clk) begin
    if (rst)            lvl <= '0;
    else if (smp_valid) lvl <= nxt;
  end
endmodule

// File: rtl/dtac_cmp.sv
// Holds the Q15 threshold and classifies the level pair.
module dtac_cmp #(
  parameter int              LVL_W   = 16,
  parameter int              THR_W   = 16,
  parameter logic [THR_W-1:0] THR_RST = 16'h4800
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [LVL_W-1:0] rin_lvl,
  input  logic [LVL_W-1:0] sin_lvl,
  input  logic             thr_wr,
  input  logic [THR_W-1:0] thr_wdata,
  output logic             out_valid,
  output logic             out_dt,
  output logic             out_unc
);
  localparam int FRAC   = THR_W - 1;
  localparam int PROD_W = LVL_W + THR_W;
  localparam int SCL_W  = PROD_W - FRAC;

  logic [THR_W-1:0]  thr_q;
  logic [PROD_W-1:0] prod;
  logic [SCL_W-1:0]  scaled;
  logic [SCL_W-1:0]  sin_ext;
  logic              dt_c;
  logic              unc_c;

  always_comb begin
    prod    = {{THR_W{1'b0}}, rin_lvl} * {{LVL_W{1'b0}}, thr_q};
    scaled  = prod[PROD_W-1:FRAC];
    sin_ext = SCL_W'(sin_lvl);
    dt_c    = sin_ext > scaled;
    unc_c   = !dt_c && (sin_ext > (scaled >> 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q     <= THR_RST;
      out_valid <= 1'b0;
      out_dt    <= 1'b0;
      out_unc   <= 1'b0;
    end else begin
      if (thr_wr) thr_q <= thr_wdata;
      out_valid <= in_valid;
      if (in_valid) begin
        out_dt  <= dt_c;
        out_unc <= unc_c;
      end
    end
  end
endmodule

// File: rtl/dtac_decide.sv
// Three-way speed decision with post double-talk hangover.
module dtac_decide
  import dtac_pkg::*;
#(
  parameter int SLOW_W   = 3,
  parameter int HANG_LEN = 256,
  parameter int HANG_W   = $clog2(HANG_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_dt,
  input  logic              in_unc,
  input  logic [SLOW_W-1:0] slow_sel,
  output adp_mode_e         mode_o,
  output logic              halt_o,
  output logic [SLOW_W-1:0] step_o,
  output logic [HANG_W-1:0] hang_o
);
  adp_mode_e         mode_n;
  logic [HANG_W-1:0] hang_n;

  always_comb begin
    hang_n = hang_o;
    mode_n = ADP_NORMAL;
    if (in_dt) begin
      hang_n = HANG_W'(HANG_LEN);
      mode_n = ADP_HALT;
    end else if (hang_o != '0) begin
      hang_n = hang_o - HANG_W'(1);
      mode_n = ADP_HALT;
    end else if (in_unc) begin
      mode_n = (slow_sel == '0) ? ADP_HALT : ADP_SLOW;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o <= ADP_NORMAL;
      halt_o <= 1'b0;
      step_o <= '0;
      hang_o <= '0;
    end else if (in_valid) begin
      mode_o <= mode_n;
      halt_o <= (mode_n == ADP_HALT);
      step_o <= (mode_n == ADP_SLOW) ? slow_sel : '0;
      hang_o <= hang_n;
    end
  end
endmodule

// File: rtl/dtalk_adapt_ctrl.sv
module dtalk_adapt_ctrl
  import dtac_pkg::*;
#(
  parameter int               DATA_W   = 16,
  parameter int               THR_W    = 16,
  parameter int               SLOW_W   = 3,
  parameter int               DECAY_SH = 5,
  parameter int               HANG_LEN = 256,
  parameter logic [THR_W-1:0] THR_RST  = 16'h4800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] rin_smp,
  input  logic [DATA_W-1:0] sin_smp,
  input  logic              thr_wr,
  input  logic [THR_W-1:0]  thr_wdata,
  input  logic [SLOW_W-1:0] slow_sel,
  output logic [1:0]        adapt_mode,
  output logic              adapt_halt,
  output logic [SLOW_W-1:0] step_shift
);
  localparam int NPATH  = 2;
  localparam int HANG_W = $clog2(HANG_LEN + 1);

  logic [NPATH-1:0][DATA_W-1:0] smp_arr;
  logic [NPATH-1:0][DATA_W-1:0] lvl_arr;
  logic                         lvl_vld;
  logic                         cmp_valid;
  logic                         cmp_dt;
  logic                         cmp_unc;
  adp_mode_e                    mode_q;
  logic [HANG_W-1:0]            hang_cnt;

  assign smp_arr[0] = rin_smp;
  assign smp_arr[1] = sin_smp;

  for (genvar gi = 0; gi < NPATH; gi++) begin : g_trk
    dtac_level #(.DATA_W(DATA_W), .DECAY_SH(DECAY_SH)) u_lvl (
      .clk(clk), .rst(rst), .smp_valid(smp_valid),
      .smp(smp_arr[gi]), .lvl(lvl_arr[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_vld <= 1'b0;
    else     lvl_vld <= smp_valid;
  end

  dtac_cmp #(.LVL_W(DATA_W), .THR_W(THR_W), .THR_RST(THR_RST)) u_cmp (
    .clk(clk), .rst(rst), .in_valid(lvl_vld),
    .rin_lvl(lvl_arr[0]), .sin_lvl(lvl_arr[1]),
    .thr_wr(thr_wr), .thr_wdata(thr_wdata),
    .out_valid(cmp_valid), .out_dt(cmp_dt), .out_unc(cmp_unc)
  );

  dtac_decide #(.SLOW_W(SLOW_W), .HANG_LEN(HANG_LEN), .HANG_W(HANG_W)) u_dec (
    .clk(clk), .rst(rst), .in_valid(cmp_valid), .in_dt(cmp_dt),
    .in_unc(cmp_unc), .slow_sel(slow_sel), .mode_o(mode_q),
    .halt_o(adapt_halt), .step_o(step_shift), .hang_o(hang_cnt)
  );

  assign adapt_mode = mode_q;
endmodule

// File: rtl/dtac_chk.sv
module dtac_chk #(
  parameter int SLOW_W   = 3,
  parameter int HANG_LEN = 256,
  parameter int HANG_W   = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              smp_valid,
  input logic [1:0]        adapt_mode,
  input logic              adapt_halt,
  input logic [SLOW_W-1:0] step_shift,
  input logic              dec_valid,
  input logic              dec_dt,
  input logic [HANG_W-1:0] hang_cnt
);
  logic sv_q1, sv_q2;
  always_ff @(posedge clk) begin
    if (rst) begin
      sv_q1 <= 1'b0;
      sv_q2 <= 1'b0;
    end else begin
      sv_q1 <= smp_valid;
      sv_q2 <= sv_q1;
    end
  end

  // R1
  mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    adapt_mode != 2'd3);

  // R4
  dt_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_dt) |=> (adapt_halt && adapt_mode == 2'd2 && hang_cnt == HANG_W'(HANG_LEN)));

  // R7
  hang_bound_chk: assert property (@(posedge clk) disable iff (rst)
    hang_cnt <= HANG_W'(HANG_LEN));

  // R7
  hang_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_dt && hang_cnt != '0) |=> (adapt_halt && step_shift == '0));

  // R5
  step_slow_chk: assert property (@(posedge clk) disable iff (rst)
    (step_shift != '0) |-> (adapt_mode == 2'd1 && !adapt_halt));

  // R8
  normal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (adapt_mode == 2'd0) |-> (step_shift == '0 && !adapt_halt));

  // R9
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !sv_q2 |=> ($stable(adapt_mode) && $stable(adapt_halt) && $stable(step_shift)));
endmodule

bind dtalk_adapt_ctrl dtac_chk #(
  .SLOW_W(SLOW_W), .HANG_LEN(HANG_LEN), .HANG_W(HANG_W)
) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid),
  .adapt_mode(adapt_mode), .adapt_halt(adapt_halt), .step_shift(step_shift),
  .dec_valid(cmp_valid), .dec_dt(cmp_dt), .hang_cnt(hang_cnt)
);

// File: tb/dtalk_adapt_ctrl_bench.sv
module dtalk_adapt_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [15:0] rin_smp = '0;
  logic [15:0] sin_smp = '0;
  logic        thr_wr = 1'b0;
  logic [15:0] thr_wdata = '0;
  logic [2:0]  slow_sel = '0;
  logic [1:0]  adapt_mode;
  logic        adapt_halt;
  logic [2:0]  step_shift;

  always #4 clk = ~clk;

  dtalk_adapt_ctrl u_dtalk_adapt_ctrl (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .rin_smp(rin_smp),
    .sin_smp(sin_smp), .thr_wr(thr_wr), .thr_wdata(thr_wdata),
    .slow_sel(slow_sel), .adapt_mode(adapt_mode), .adapt_halt(adapt_halt),
    .step_shift(step_shift)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  // model state
  longint m_rin, m_sin, m_thr;
  int m_hang;
  int e_mode, e_halt, e_step;
  string e_tag;

  function automatic longint mag_of(int x);
    return (x < 0) ? -longint'(x) : longint'(x);
  endfunction

  function automatic longint track(longint lvl, int x);
    longint m = mag_of(x);
    longint d = lvl - (lvl >> 5);
    return (m > d) ? m : d;
  endfunction

  task automatic model_reset();
    m_rin = 0; m_sin = 0; m_thr = 'h4800; m_hang = 0;
    e_mode = 0; e_halt = 0; e_step = 0;
  endtask

  task automatic model_step(int rin, int sin, int slow);
    longint sc;
    bit dt, unc;
    m_rin = track(m_rin, rin);
    m_sin = track(m_sin, sin);
    sc  = (m_rin * m_thr) >> 15;
    dt  = m_sin > sc;
    unc = !dt && (m_sin > (sc >> 1));
    e_step = 0;
    if (dt) begin
      m_hang = 256; e_mode = 2; e_tag = "R4";
    end else if (m_hang > 0) begin
      m_hang--; e_mode = 2; e_tag = "R7";
    end else if (unc && slow == 0) begin
      e_mode = 2; e_tag = "R6";
    end else if (unc) begin
      e_mode = 1; e_step = slow; e_tag = "R5";
    end else begin
      e_mode = 0; e_tag = "R8";
    end
    e_halt = (e_mode == 2) ? 1 : 0;
  endtask

  task automatic check_out(int mode, int halt, int step, string tag);
    n_chk++;
    if (int'(adapt_mode) != mode || int'(adapt_halt) != halt || int'(step_shift) != step) begin
      n_fail++;
      $display("FAIL %s: mode=%0d halt=%0d step=%0d expected mode=%0d halt=%0d step=%0d",
               tag, adapt_mode, adapt_halt, step_shift, mode, halt, step);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; smp_valid = 1'b0; thr_wr = 1'b0;
    repeat (3) @(negedge clk);
    check_out(0, 0, 0, "R1");
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    check_out(0, 0, 0, "R1");
  endtask

  task automatic write_thr(int v);
    @(negedge clk);
    thr_wr = 1'b1; thr_wdata = 16'(v);
    @(negedge clk);
    thr_wr = 1'b0;
    m_thr = v;
  endtask

  // drives one sample; returns after the decision is visible
  task automatic do_sample(int rin, int sin, int slow, string tag);
    int pm, ph, ps;
    pm = e_mode; ph = e_halt; ps = e_step;
    @(negedge clk);
    slow_sel = 3'(slow); rin_smp = 16'(rin); sin_smp = 16'(sin); smp_valid = 1'b1;
    model_step(rin, sin, slow);
    @(negedge clk);
    smp_valid = 1'b0;
    check_out(pm, ph, ps, "R9");   // still old decision one edge later
    @(negedge clk);
    check_out(pm, ph, ps, "R9");
    @(negedge clk);
    check_out(e_mode, e_halt, e_step, (tag == "") ? e_tag : tag);
  endtask

  task automatic expect_lit(int mode, int halt, int step, string tag);
    n_chk++;
    if (e_mode != mode || int'(adapt_mode) != mode || int'(adapt_halt) != halt ||
        int'(step_shift) != step) begin
      n_fail++;
      $display("FAIL %s: mode=%0d halt=%0d step=%0d expected mode=%0d halt=%0d step=%0d",
               tag, adapt_mode, adapt_halt, step_shift, mode, halt, step);
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    do_reset();

    // R3: reset threshold 0x4800 -> scaled 5625 for far level 10000
    do_sample(10000, 5700, 2, "R3");
    expect_lit(2, 1, 0, "R3");
    do_reset();
    do_sample(10000, 5600, 2, "R3");
    expect_lit(1, 0, 2, "R3");
    // R3: written threshold used by the very next sample
    do_reset();
    write_thr('h2000);
    do_sample(10000, 3000, 2, "R3");
    expect_lit(2, 1, 0, "R3");

    // R6: doubtful band with zero slow field halts
    do_reset();
    do_sample(10000, 4000, 0, "R6");
    expect_lit(2, 1, 0, "R6");
    // R5: same band, slow field 7
    do_reset();
    do_sample(10000, 4000, 7, "R5");
    expect_lit(1, 0, 7, "R5");

    // R2: decay of 1/32 per sample on the far level
    do_reset();
    write_thr('h7FFF);
    do_sample(32000, 0, 1, "R8");
    expect_lit(0, 0, 0, "R8");
    do_sample(0, 30500, 1, "R2");
    expect_lit(1, 0, 1, "R2");
    // R2: most negative sample has magnitude 32768
    do_reset();
    write_thr('h7FFF);
    do_sample(-32768, -32768, 1, "R2");
    expect_lit(2, 1, 0, "R2");

    // R7: burst then long near-end silence; hangover overlaps doubtful band
    do_reset();
    do_sample(10000, 20000, 1, "R4");
    expect_lit(2, 1, 0, "R4");
    for (int i = 0; i < 300; i++) do_sample(32000, 0, 1, "");
    expect_lit(0, 0, 0, "R7");

    // random traffic
    for (int i = 0; i < 700; i++) begin
      int rin, sin, k, slow;
      if (i % 60 == 0) write_thr(int'($urandom_range(32'h7FFF, 32'h0800)));
      if (i % 97 == 0) do_reset();
      rin  = int'($urandom_range(65535, 0)) - 32768;
      k    = int'($urandom_range(12, 0));
      sin  = int'((mag_of(rin) * k) / 8);
      if (sin > 32767) sin = 32767;
      if ($urandom_range(1, 0) == 1) sin = -sin;
      if ($urandom_range(9, 0) == 0) rin = 0;
      slow = int'($urandom_range(7, 0));
      do_sample(rin, sin, slow, "");
      if ($urandom_range(7, 0) == 0) repeat (int'($urandom_range(5, 1))) @(negedge clk);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule